// File: doc/BRIEF.md
# Mailbox Memory Loader with CRC

This block gives a host a window into an embedded processor's memory through a narrow 16-bit management register interface. The host programs a start address in two halves. It then streams the image one 32-bit word at a time: it writes the two data halves and issues a write command through the control register. For each command the block drives a single-cycle write on a synchronous memory port and steps the address to the next word.

While the memory write happens, the block also folds the committed word into a running CRC-16 that the host can read back. Bytes enter most significant first, one per clock. A host that keeps its own CRC over the image can therefore confirm the transfer when it ends. A control bit clears the accumulator before a new region is loaded. A busy flag covers the memory write and the four CRC steps. Commands that arrive while it is set are dropped.

Top module: `mbox_loader`

## Requirements
- R1: After reset, busy and mem_we are 0, and every register at offsets 0x0200 to 0x0205 reads 0x0000.
- R2: The address high half is written and read at offset 0x0202 and the low half at 0x0203. Bits [1:0] of the low half are always stored as zero, so mem_addr is always word-aligned.
- R3: The data high half (offset 0x0204) and low half (offset 0x0205) read back as written. The control register (offset 0x0200) reads bit 8 as busy and every other bit as zero.
- R4: A control write with bit 15 (execute) and bit 14 (write select) both set, made while idle, drives mem_we high for exactly one cycle, starting the cycle after the write. During that cycle mem_addr equals the programmed address and mem_wdata equals {high half, low half}.
- R5: Each executed write adds 4 to the stored address, modulo 2^32, and the address registers read back the advanced value.
- R6: Offset 0x0201 returns a CRC-16 (polynomial 0x1021, not reflected, no final XOR). It is accumulated over every committed word, with bits [31:24] first and bits [7:0] last.
- R7: A control write with bit 12 set, made while idle, clears the CRC to 0x0000 on the next cycle. With busy low and no such write, the CRC holds its value.
- R8: Busy rises the cycle after an accepted execute and stays high for exactly 4 cycles.
- R9: A control write made while busy is high is ignored completely. It starts no memory write and does not clear the CRC.
- R10: A control write with execute set but write select clear causes no memory write, no address change and no CRC change.
- R11: When bit 12 and an accepted execute-write arrive in the same control write, the CRC is cleared first, and the word is then folded into the zero value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register offset for write and read |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| busy | output | 1 | Word commit and CRC update in progress |
| mem_we | output | 1 | Memory write strobe, one cycle per word |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |

## Verification
Two functions can land in the same cycle: clearing the CRC and committing a word. They collide when one control write carries both the clear bit and the execute-write pair. The bench triggers this while the accumulator holds a non-zero value. A correct result is the CRC of that single word alone, starting from zero, together with the expected memory write. The bench also sends the same combined command in the cycle after an accepted execute, while busy is high. In that case it expects neither the clear nor a second write: the final CRC must cover both words, and the address must have advanced only once.

// File: rtl/mbx_pkg.sv
// Package: shared control-register bit positions and the register select type
// for the mailbox loader. Assumes a 16-bit register interface.
package mbx_pkg;

    localparam int CTL_EXEC_BIT  = 15;
    localparam int CTL_WRSEL_BIT = 14;
    localparam int CTL_CLR_BIT   = 12;
    localparam int CTL_BUSY_BIT  = 8;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_CRC,
        SEL_ADRH,
        SEL_ADRL,
        SEL_DATH,
        SEL_DATL
    } reg_sel_e;

endpackage

// File: rtl/mbx_regs.sv
// mbx_regs: decodes the six mailbox registers, holds the address and data
// halves, produces the accepted execute and CRC clear pulses and the read mux.
// Assumes a single write port; a control write while busy is dropped whole.
module mbx_regs
    import mbx_pkg::*;
#(
    parameter int             RW   = 16,
    parameter int             RAW  = 16,
    parameter int             CW   = 16,
    parameter logic [RAW-1:0] BASE = 16'h0200
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [RAW-1:0]  reg_addr,
    input  logic [RW-1:0]   reg_wdata,
    output logic [RW-1:0]   reg_rdata,
    input  logic            busy,
    input  logic [CW-1:0]   crc_val,
    output logic [2*RW-1:0] word_addr,
    output logic [2*RW-1:0] word_data,
    output logic            exec_go,
    output logic            crc_clr
);

    localparam int WW         = 2 * RW;
    localparam int STEP       = WW / 8;
    localparam int ALIGN_BITS = $clog2(STEP);

    reg_sel_e        sel;
    logic [RW-1:0]   adr_hi_q, adr_lo_q, dat_hi_q, dat_lo_q;
    logic            ctrl_wr;

    // Map the register offset onto a register select.
    always_comb begin
        if (reg_addr == BASE)                       sel = SEL_CTRL;
        else if (reg_addr == BASE + RAW'(1))        sel = SEL_CRC;
        else if (reg_addr == BASE + RAW'(2))        sel = SEL_ADRH;
        else if (reg_addr == BASE + RAW'(3))        sel = SEL_ADRL;
        else if (reg_addr == BASE + RAW'(4))        sel = SEL_DATH;
        else if (reg_addr == BASE + RAW'(5))        sel = SEL_DATL;
        else                                        sel = SEL_NONE;
    end

    // Control commands are accepted only when idle.
    always_comb begin
        ctrl_wr = reg_we && (sel == SEL_CTRL) && !busy;
        exec_go = ctrl_wr && reg_wdata[CTL_EXEC_BIT] && reg_wdata[CTL_WRSEL_BIT];
        crc_clr = ctrl_wr && reg_wdata[CTL_CLR_BIT];
    end

    // Address halves: host load, or advance by one word after each commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adr_hi_q <= '0;
            adr_lo_q <= '0;
        end else if (exec_go) begin
            {adr_hi_q, adr_lo_q} <= {adr_hi_q, adr_lo_q} + WW'(STEP);
        end else if (reg_we && sel == SEL_ADRH) begin
            adr_hi_q <= reg_wdata;
        end else if (reg_we && sel == SEL_ADRL) begin
            adr_lo_q <= {reg_wdata[RW-1:ALIGN_BITS], ALIGN_BITS'(0)};
        end
    end

    // Data halves: plain host-written staging registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat_hi_q <= '0;
            dat_lo_q <= '0;
        end else if (reg_we && sel == SEL_DATH) begin
            dat_hi_q <= reg_wdata;
        end else if (reg_we && sel == SEL_DATL) begin
            dat_lo_q <= reg_wdata;
        end
    end

    assign word_addr = {adr_hi_q, adr_lo_q};
    assign word_data = {dat_hi_q, dat_lo_q};

    // Read mux; command bits always read as zero.
    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_CTRL: reg_rdata[CTL_BUSY_BIT] = busy;
            SEL_CRC:  reg_rdata = RW'(crc_val);
            SEL_ADRH: reg_rdata = adr_hi_q;
            SEL_ADRL: reg_rdata = adr_lo_q;
            SEL_DATH: reg_rdata = dat_hi_q;
            SEL_DATL: reg_rdata = dat_lo_q;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mbx_seq.sv
// mbx_seq: on an accepted execute, issues one memory write and then presents
// the committed word to the CRC engine one byte per cycle, MSB first.
// Assumes go only arrives while busy is low.
module mbx_seq #(
    parameter int DW = 32,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          busy,
    output logic          byte_vld,
    output logic [7:0]    byte_out
);

    localparam int NBYTES = DW / 8;
    localparam int CNTW   = $clog2(NBYTES + 1);
    localparam int IW     = $clog2(NBYTES);

    logic [CNTW-1:0] cnt_q;
    logic [DW-1:0]   word_q;
    logic [7:0]      lane [NBYTES];
    logic [IW-1:0]   idx;

    // Split the held word into byte lanes.
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign lane[g] = word_q[g*8 +: 8];
    end

    // Memory port: one strobe cycle per accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= go;
            if (go) begin
                mem_addr  <= addr_in;
                mem_wdata <= data_in;
            end
        end
    end

    // Byte countdown that defines the busy window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy   <= 1'b0;
            word_q <= '0;
        end else if (go) begin
            cnt_q  <= CNTW'(NBYTES);
            busy   <= 1'b1;
            word_q <= data_in;
        end else if (busy) begin
            cnt_q <= cnt_q - CNTW'(1);
            busy  <= (cnt_q != CNTW'(1));
        end
    end

    assign idx      = IW'(cnt_q - CNTW'(1));
    assign byte_vld = busy;
    assign byte_out = lane[idx];

endmodule

// File: rtl/mbx_crc.sv
// mbx_crc: byte-serial, non-reflected CRC with zero init and no final XOR.
// The eight bit steps are unrolled into one combinational chain.
// Assumes clr and vld are never high together.
module mbx_crc #(
    parameter int          CW   = 16,
    parameter logic [CW-1:0] POLY = 16'h1021
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          vld,
    input  logic [7:0]    din,
    output logic [CW-1:0] crc
);

    logic [CW-1:0] crc_q;
    logic [CW-1:0] stage [9];

    assign stage[0] = crc_q ^ (CW'(din) << (CW - 8));

    for (genvar g = 0; g < 8; g++) begin : g_bit
        assign stage[g+1] = stage[g][CW-1] ? ((stage[g] << 1) ^ POLY)
                                           : (stage[g] << 1);
    end

    // Accumulator: cleared on command, advanced one byte per valid cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      crc_q <= '0;
        else if (clr)    crc_q <= '0;
        else if (vld)    crc_q <= stage[8];
    end

    assign crc = crc_q;

endmodule

// File: rtl/mbox_loader.sv
// mbox_loader: top of the mailbox loader. Ties the register file, the commit
// sequencer and the CRC engine together. Assumes one register access per cycle.
module mbox_loader #(
    parameter int             RW   = 16,
    parameter int             RAW  = 16,
    parameter logic [RAW-1:0] BASE = 16'h0200,
    parameter int             CW   = 16,
    parameter logic [CW-1:0]  POLY = 16'h1021
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [RAW-1:0]  reg_addr,
    input  logic [RW-1:0]   reg_wdata,
    output logic [RW-1:0]   reg_rdata,
    output logic            busy,
    output logic            mem_we,
    output logic [2*RW-1:0] mem_addr,
    output logic [2*RW-1:0] mem_wdata
);

    localparam int WW = 2 * RW;

    logic [WW-1:0] word_addr, word_data;
    logic          exec_go, crc_clr, byte_vld;
    logic [7:0]    byte_val;
    logic [CW-1:0] crc_q;

    mbx_regs #(.RW(RW), .RAW(RAW), .CW(CW), .BASE(BASE)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .crc_val   (crc_q),
        .word_addr (word_addr),
        .word_data (word_data),
        .exec_go   (exec_go),
        .crc_clr   (crc_clr)
    );

    mbx_seq #(.DW(WW), .AW(WW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (exec_go),
        .addr_in   (word_addr),
        .data_in   (word_data),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .busy      (busy),
        .byte_vld  (byte_vld),
        .byte_out  (byte_val)
    );

    mbx_crc #(.CW(CW), .POLY(POLY)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .vld   (byte_vld),
        .din   (byte_val),
        .crc   (crc_q)
    );

endmodule

// File: rtl/mbox_loader_chk.sv
// mbox_loader_chk: protocol checks for the mailbox loader, bound to the top.
module mbox_loader_chk #(
    parameter int             RW     = 16,
    parameter int             RAW    = 16,
    parameter logic [RAW-1:0] BASE   = 16'h0200,
    parameter int             CW     = 16,
    parameter int             NBYTES = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_we,
    input logic [RAW-1:0]  reg_addr,
    input logic [RW-1:0]   reg_wdata,
    input logic            busy,
    input logic            mem_we,
    input logic [2*RW-1:0] mem_addr,
    input logic [CW-1:0]   crc_val
);

    localparam int RUNW = $clog2(NBYTES + 2);

    logic            ctl_wr, acc, clr_ok;
    logic [RUNW-1:0] run_q;

    assign ctl_wr = reg_we && (reg_addr == BASE);
    assign acc    = ctl_wr && !busy && reg_wdata[15] && reg_wdata[14];
    assign clr_ok = ctl_wr && !busy && reg_wdata[12];

    // Length of the current busy run, in cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy)          run_q <= '0;
        else if (run_q != '1)         run_q <= run_q + RUNW'(1);
    end

    AST_EXEC_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (busy && mem_we));                                   // R4
    AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);                                         // R4
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[1:0] == 2'b00));                        // R2
    AST_BUSY_DROPS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && busy) |=> !mem_we);                               // R9
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < RUNW'(NBYTES)));                           // R8
    AST_BUSY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == RUNW'(NBYTES)));                   // R8
    AST_CRC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ok |=> (crc_val == '0));                                 // R7
    AST_CRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !clr_ok) |=> $stable(crc_val));                    // R7

endmodule

bind mbox_loader mbox_loader_chk #(
    .RW(RW), .RAW(RAW), .BASE(BASE), .CW(CW), .NBYTES((2*RW)/8)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .crc_val   (crc_q)
);

// File: tb/mbox_loader_tb.sv
`timescale 1ns/1ps
module mbox_loader_tb;

    localparam logic [15:0] O_CTRL = 16'h0200;
    localparam logic [15:0] O_CRC  = 16'h0201;
    localparam logic [15:0] O_ADRH = 16'h0202;
    localparam logic [15:0] O_ADRL = 16'h0203;
    localparam logic [15:0] O_DATH = 16'h0204;
    localparam logic [15:0] O_DATL = 16'h0205;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        busy, mem_we;
    logic [31:0] mem_addr, mem_wdata;

    int          n_tests = 0;
    int          n_fail  = 0;
    bit          finished = 1'b0;
    logic [63:0] exp_q[$];
    logic [31:0] m_addr;
    logic [15:0] m_crc;

    always #2 clk = ~clk;

    mbox_loader u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    function automatic logic [15:0] crc_fold(input logic [15:0] c, input logic [31:0] w);
        logic [15:0] r = c;
        for (int i = 0; i < 4; i++) begin
            r = r ^ {w[31-8*i -: 8], 8'h00};
            for (int b = 0; b < 8; b++)
                r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [15:0] a, output logic [15:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    // Driver: stage a word, queue the expected memory write, then execute.
    task automatic push_word(input logic [31:0] w, input logic [15:0] cmd, input bit fresh);
        reg_wr(O_DATH, w[31:16]);
        reg_wr(O_DATL, w[15:0]);
        exp_q.push_back({m_addr, w});
        m_crc  = crc_fold(fresh ? 16'h0000 : m_crc, w);
        m_addr = m_addr + 32'd4;
        reg_wr(O_CTRL, cmd);
    endtask

    // Monitor: compare each memory write with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && mem_we && !finished) begin
            if (exp_q.size() == 0) begin
                n_tests++; n_fail++;
                $display("FAIL R9/R10 unexpected write actual=%h expected=none", mem_addr);
            end else begin
                logic [63:0] e;
                e = exp_q.pop_front();
                check("R4 mem_addr", mem_addr, e[63:32]);
                check("R4 mem_wdata", mem_wdata, e[31:0]);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int cnt;
        logic [31:0] words [5];
        words[0] = 32'h1234ABCD; words[1] = 32'h00000000; words[2] = 32'hFFFFFFFF;
        words[3] = 32'h80000001; words[4] = 32'h5A5AC3C3;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 mem_we", mem_we, 0);
        for (int i = 0; i < 6; i++) begin
            reg_rd(O_CTRL + 16'(i), v);
            check("R1 reg", v, 0);
        end

        // R2 address halves and alignment
        reg_wr(O_ADRH, 16'h3FFE);
        reg_wr(O_ADRL, 16'h0007);
        reg_rd(O_ADRH, v); check("R2 adr hi", v, 16'h3FFE);
        reg_rd(O_ADRL, v); check("R2 adr lo aligned", v, 16'h0004);
        m_addr = 32'h3FFE0004;
        m_crc  = 16'h0000;

        // R3 data readback
        reg_wr(O_DATH, 16'hBEEF);
        reg_wr(O_DATL, 16'h0F0F);
        reg_rd(O_DATH, v); check("R3 data hi", v, 16'hBEEF);
        reg_rd(O_DATL, v); check("R3 data lo", v, 16'h0F0F);

        // R4 R5 R6 R8 stream of words
        for (int k = 0; k < 5; k++) begin
            push_word(words[k], 16'hC000, 1'b0);
            if (k == 0) begin
                reg_rd(O_CTRL, v); check("R3 ctrl busy read", v, 16'h0100);
            end
            cnt = 0;
            while (busy) begin cnt++; @(negedge clk); end
            check("R8 busy length", cnt, 4);
        end
        reg_rd(O_ADRH, v); check("R5 adr hi advanced", v, m_addr[31:16]);
        reg_rd(O_ADRL, v); check("R5 adr lo advanced", v, m_addr[15:0]);
        reg_rd(O_CRC, v);  check("R6 crc stream", v, m_crc);
        reg_rd(O_CTRL, v); check("R3 ctrl idle read", v, 16'h0000);

        // R7 clear
        reg_wr(O_CTRL, 16'h1000);
        m_crc = 16'h0000;
        reg_rd(O_CRC, v); check("R7 crc cleared", v, 16'h0000);

        // R10 execute without write select
        reg_wr(O_CTRL, 16'h8000);
        repeat (6) @(negedge clk);
        reg_rd(O_ADRL, v); check("R10 adr unchanged", v, m_addr[15:0]);
        reg_rd(O_CRC, v);  check("R10 crc unchanged", v, 16'h0000);
        check("R10 not busy", busy, 0);

        // R9 command while busy is dropped
        push_word(32'hCAFEF00D, 16'hC000, 1'b0);
        wait_idle();
        push_word(32'h0BADC0DE, 16'hC000, 1'b0);
        reg_wr(O_CTRL, 16'hD000);
        wait_idle();
        repeat (2) @(negedge clk);
        reg_rd(O_CRC, v);  check("R9 crc kept", v, m_crc);
        reg_rd(O_ADRL, v); check("R9 adr single step", v, m_addr[15:0]);

        // R11 clear and execute together
        push_word(32'h13579BDF, 16'hD000, 1'b1);
        wait_idle();
        reg_rd(O_CRC, v); check("R11 crc from zero", v, m_crc);

        // R5 wrap
        reg_wr(O_ADRH, 16'hFFFF);
        reg_wr(O_ADRL, 16'hFFFC);
        m_addr = 32'hFFFFFFFC;
        push_word(32'h2468ACE0, 16'hC000, 1'b0);
        wait_idle();
        reg_rd(O_ADRH, v); check("R5 wrap hi", v, 16'h0000);
        reg_rd(O_ADRL, v); check("R5 wrap lo", v, 16'h0000);
        reg_rd(O_CRC, v);  check("R6 crc after wrap", v, m_crc);

        repeat (3) @(negedge clk);
        check("R4 queue drained", exp_q.size(), 0);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule